// File: doc/BRIEF.md
# Dual-Path Floating-Point Operand Dispatcher

This block sits ahead of a floating-point adder whose significand datapath splits into two lanes. One lane, CLOSE, serves operands whose exponents are at most one apart. The other lane, FAR, serves operands with larger exponent gaps and effective additions. Each cycle the dispatcher looks at the two oldest pending add or subtract requests, held in slot 0 (older) and slot 1 (younger). It classifies each request by its effective operation and exponent gap, then places the requests on the lanes. When their lane needs do not collide, two independent operations leave in the same cycle.

Operands are 32-bit single-precision words. Bit 31 is the sign, bits 30:23 the biased exponent and bits 22:0 the fraction. Each lane has its own copy of the exponent and sign precompute logic, so two operations issued together each carry their own gap, larger exponent, swap flag and result sign. A one-bit sequence tag on every issued operation lets downstream logic put the results back into program order. Each lane output uses a ready/valid handshake. The slots see per-slot accept pulses. A slot holds its request until the request is accepted.

Top module: `fpadd_dispatch`

## Requirements
- R1: An effective subtraction whose exponent gap is 0 or 1 is only ever issued on the CLOSE lane.
- R2: An effective subtraction whose exponent gap is 2 or more, and an effective addition whose gap is 2 or more, are only ever issued on the FAR lane.
- R3: The effective operation is subtraction exactly when (sign of a) XOR (sign of b) XOR sub is 1, where sub=1 requests a - b and sub=0 requests a + b. The lane output `*_eff_sub` carries this value.
- R4: An effective addition with a gap of 0 or 1 is flexible. Issued alone, it goes to FAR. When both requests are flexible, the older goes to FAR and the younger to CLOSE. A flexible older request goes to CLOSE only when the younger request needs FAR.
- R5: When the two requests fit on different lanes and both lanes are ready, both are issued and both slots are accepted in the same cycle.
- R6: When both requests need the same lane, only the older one is issued. Slot 1 is not accepted and is served in a later cycle.
- R7: Slot 1 is never accepted unless slot 0 is accepted in the same cycle. Slot 1 is ignored while slot 0 is not valid.
- R8: A request whose lane has ready low is not accepted, and its lane valid stays high. If the older request stalls, the younger request is not issued.
- R9: After reset the tag counter is 0. The older issued request carries the counter value, and a younger request issued with it carries the inverse. The counter toggles when exactly one request is accepted and holds when two are accepted.
- R10: Each lane outputs the absolute difference of the two biased exponents, the larger exponent, and a swap flag that is 1 exactly when b's exponent exceeds a's.
- R11: Each lane outputs the result sign. For an effective addition it is a's sign. For an effective subtraction it is the sign of the operand with the larger magnitude (bits 30:0), where b's sign is taken as (sign of b) XOR sub. When the magnitudes are equal under effective subtraction it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s0_valid | input | 1 | Older slot holds a request |
| s0_a | input | 32 | Older slot operand a |
| s0_b | input | 32 | Older slot operand b |
| s0_sub | input | 1 | Older slot opcode, 1 = subtract |
| s0_accept | output | 1 | Older slot request taken this cycle |
| s1_valid | input | 1 | Younger slot holds a request |
| s1_a | input | 32 | Younger slot operand a |
| s1_b | input | 32 | Younger slot operand b |
| s1_sub | input | 1 | Younger slot opcode, 1 = subtract |
| s1_accept | output | 1 | Younger slot request taken this cycle |
| cl_valid | output | 1 | CLOSE lane issue valid |
| cl_ready | input | 1 | CLOSE lane can take an operation |
| cl_a | output | 32 | CLOSE lane operand a |
| cl_b | output | 32 | CLOSE lane operand b |
| cl_eff_sub | output | 1 | CLOSE lane effective subtraction |
| cl_tag | output | 1 | CLOSE lane sequence tag |
| cl_exp_diff | output | 8 | CLOSE lane exponent gap |
| cl_swap | output | 1 | CLOSE lane: b has larger exponent |
| cl_exp | output | 8 | CLOSE lane larger exponent |
| cl_sign | output | 1 | CLOSE lane result sign |
| fr_valid | output | 1 | FAR lane issue valid |
| fr_ready | input | 1 | FAR lane can take an operation |
| fr_a | output | 32 | FAR lane operand a |
| fr_b | output | 32 | FAR lane operand b |
| fr_eff_sub | output | 1 | FAR lane effective subtraction |
| fr_tag | output | 1 | FAR lane sequence tag |
| fr_exp_diff | output | 8 | FAR lane exponent gap |
| fr_swap | output | 1 | FAR lane: b has larger exponent |
| fr_exp | output | 8 | FAR lane larger exponent |
| fr_sign | output | 1 | FAR lane result sign |

## Verification
The assertions assume the slots behave like the head of an in-order queue. Slot 1 is only meaningful behind a valid slot 0, and a slot's contents stay fixed until it is accepted. Operands are ordinary finite numbers, so no special-value handling is expected. The stimulus keeps to these assumptions by presenting the first two entries of a pending list and removing entries only after they are accepted. The single exception is one deliberate case with slot 1 valid and slot 0 empty, which checks that the younger slot is ignored. Exponents are drawn from a narrow band so that gaps of 0, 1 and more all occur often. Lane readiness is varied to exercise stalls.

// File: rtl/fpadd_dispatch_pkg.sv
package fpadd_dispatch_pkg;

    // lane requirement of one request
    typedef enum logic [1:0] {
        NEED_CLOSE  = 2'd0,
        NEED_FAR    = 2'd1,
        NEED_EITHER = 2'd2
    } lane_need_e;

    localparam int LANE_CLOSE = 0;
    localparam int LANE_FAR   = 1;
    localparam int NUM_LANES  = 2;

    typedef struct packed {
        logic tag;
    } disp_state_t;

endpackage

// File: rtl/fp_route_class.sv
module fp_route_class
    import fpadd_dispatch_pkg::*;
#(
    parameter int EXP_W = 8
) (
    input  logic             sgn_a,
    input  logic             sgn_b,
    input  logic [EXP_W-1:0] exp_a,
    input  logic [EXP_W-1:0] exp_b,
    input  logic             sub,
    output lane_need_e       need
);
    logic             eff_sub;
    logic [EXP_W-1:0] gap;
    logic             near;

    always_comb begin
        eff_sub = sgn_a ^ sgn_b ^ sub;
        gap     = (exp_a >= exp_b) ? (exp_a - exp_b) : (exp_b - exp_a);
        near    = (gap <= EXP_W'(1));
        if (near && eff_sub)       need = NEED_CLOSE;
        else if (near)             need = NEED_EITHER;
        else                       need = NEED_FAR;
    end

endmodule

// File: rtl/fp_lane_pre.sv
module fp_lane_pre #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0]     op_a,
    input  logic [W-1:0]     op_b,
    input  logic             sub,
    output logic             eff_sub,
    output logic [EXP_W-1:0] exp_diff,
    output logic             swap,
    output logic [EXP_W-1:0] exp_big,
    output logic             sign
);
    logic [EXP_W-1:0] ea, eb;
    logic [W-2:0]     ma, mb;
    logic             sb_eff;

    always_comb begin
        ea       = op_a[W-2:FRAC_W];
        eb       = op_b[W-2:FRAC_W];
        ma       = op_a[W-2:0];
        mb       = op_b[W-2:0];
        sb_eff   = op_b[W-1] ^ sub;
        eff_sub  = op_a[W-1] ^ sb_eff;
        swap     = (eb > ea);
        exp_diff = swap ? (eb - ea) : (ea - eb);
        exp_big  = swap ? eb : ea;
        if (!eff_sub)      sign = op_a[W-1];
        else if (ma == mb) sign = 1'b0;
        else if (mb > ma)  sign = sb_eff;
        else               sign = op_a[W-1];
    end

endmodule

// File: rtl/fpadd_dispatch.sv
module fpadd_dispatch
    import fpadd_dispatch_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s0_valid,
    input  logic [W-1:0]     s0_a,
    input  logic [W-1:0]     s0_b,
    input  logic             s0_sub,
    output logic             s0_accept,
    input  logic             s1_valid,
    input  logic [W-1:0]     s1_a,
    input  logic [W-1:0]     s1_b,
    input  logic             s1_sub,
    output logic             s1_accept,
    output logic             cl_valid,
    input  logic             cl_ready,
    output logic [W-1:0]     cl_a,
    output logic [W-1:0]     cl_b,
    output logic             cl_eff_sub,
    output logic             cl_tag,
    output logic [EXP_W-1:0] cl_exp_diff,
    output logic             cl_swap,
    output logic [EXP_W-1:0] cl_exp,
    output logic             cl_sign,
    output logic             fr_valid,
    input  logic             fr_ready,
    output logic [W-1:0]     fr_a,
    output logic [W-1:0]     fr_b,
    output logic             fr_eff_sub,
    output logic             fr_tag,
    output logic [EXP_W-1:0] fr_exp_diff,
    output logic             fr_swap,
    output logic [EXP_W-1:0] fr_exp,
    output logic             fr_sign
);

    disp_state_t state_d, state_q;
    lane_need_e  need_old, need_young;

    logic        v_old, v_young;
    logic        old_on_close;
    logic        pair_fits;
    logic        old_rdy, young_rdy;
    logic        young_go;
    logic        acc_old, acc_young;
    logic [NUM_LANES-1:0] lane_valid;
    logic [NUM_LANES-1:0] lane_takes_young;

    // classification per slot, ahead of the lane split
    fp_route_class #(.EXP_W(EXP_W)) u_cls_old (
        .sgn_a (s0_a[W-1]),
        .sgn_b (s0_b[W-1]),
        .exp_a (s0_a[W-2:FRAC_W]),
        .exp_b (s0_b[W-2:FRAC_W]),
        .sub   (s0_sub),
        .need  (need_old)
    );

    fp_route_class #(.EXP_W(EXP_W)) u_cls_young (
        .sgn_a (s1_a[W-1]),
        .sgn_b (s1_b[W-1]),
        .exp_a (s1_a[W-2:FRAC_W]),
        .exp_b (s1_b[W-2:FRAC_W]),
        .sub   (s1_sub),
        .need  (need_young)
    );

    always_comb begin
        state_d = state_q;
        v_old   = s0_valid;
        v_young = s0_valid && s1_valid;

        // older lane choice: flexible older yields CLOSE only to a FAR-bound younger
        old_on_close = (need_old == NEED_CLOSE) ||
                       ((need_old == NEED_EITHER) && v_young && (need_young == NEED_FAR));

        if (old_on_close) pair_fits = v_young && (need_young != NEED_CLOSE);
        else              pair_fits = v_young && (need_young != NEED_FAR);

        old_rdy   = old_on_close ? cl_ready : fr_ready;
        young_rdy = old_on_close ? fr_ready : cl_ready;
        young_go  = pair_fits && old_rdy;

        acc_old   = v_old && old_rdy;
        acc_young = young_go && young_rdy;

        lane_valid[LANE_CLOSE] = (v_old && old_on_close) || (young_go && !old_on_close);
        lane_valid[LANE_FAR]   = (v_old && !old_on_close) || (young_go && old_on_close);
        lane_takes_young[LANE_CLOSE] = !old_on_close;
        lane_takes_young[LANE_FAR]   = old_on_close;

        if (acc_old ^ acc_young) state_d.tag = ~state_q.tag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // per-lane operand steering and duplicated exponent/sign precompute
    logic [W-1:0]     ln_a     [NUM_LANES];
    logic [W-1:0]     ln_b     [NUM_LANES];
    logic             ln_sub   [NUM_LANES];
    logic             ln_tag   [NUM_LANES];
    logic             ln_esub  [NUM_LANES];
    logic [EXP_W-1:0] ln_diff  [NUM_LANES];
    logic             ln_swap  [NUM_LANES];
    logic [EXP_W-1:0] ln_exp   [NUM_LANES];
    logic             ln_sign  [NUM_LANES];

    for (genvar gl = 0; gl < NUM_LANES; gl++) begin : g_lane
        always_comb begin
            ln_a[gl]   = lane_takes_young[gl] ? s1_a   : s0_a;
            ln_b[gl]   = lane_takes_young[gl] ? s1_b   : s0_b;
            ln_sub[gl] = lane_takes_young[gl] ? s1_sub : s0_sub;
            ln_tag[gl] = lane_takes_young[gl] ? ~state_q.tag : state_q.tag;
        end

        fp_lane_pre #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pre (
            .op_a     (ln_a[gl]),
            .op_b     (ln_b[gl]),
            .sub      (ln_sub[gl]),
            .eff_sub  (ln_esub[gl]),
            .exp_diff (ln_diff[gl]),
            .swap     (ln_swap[gl]),
            .exp_big  (ln_exp[gl]),
            .sign     (ln_sign[gl])
        );
    end

    assign s0_accept   = acc_old;
    assign s1_accept   = acc_young;

    assign cl_valid    = lane_valid[LANE_CLOSE];
    assign cl_a        = ln_a[LANE_CLOSE];
    assign cl_b        = ln_b[LANE_CLOSE];
    assign cl_eff_sub  = ln_esub[LANE_CLOSE];
    assign cl_tag      = ln_tag[LANE_CLOSE];
    assign cl_exp_diff = ln_diff[LANE_CLOSE];
    assign cl_swap     = ln_swap[LANE_CLOSE];
    assign cl_exp      = ln_exp[LANE_CLOSE];
    assign cl_sign     = ln_sign[LANE_CLOSE];

    assign fr_valid    = lane_valid[LANE_FAR];
    assign fr_a        = ln_a[LANE_FAR];
    assign fr_b        = ln_b[LANE_FAR];
    assign fr_eff_sub  = ln_esub[LANE_FAR];
    assign fr_tag      = ln_tag[LANE_FAR];
    assign fr_exp_diff = ln_diff[LANE_FAR];
    assign fr_swap     = ln_swap[LANE_FAR];
    assign fr_exp      = ln_exp[LANE_FAR];
    assign fr_sign     = ln_sign[LANE_FAR];

    // R1
    close_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cl_valid |-> (cl_exp_diff <= EXP_W'(1)));

    // R2
    far_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_valid && fr_eff_sub) |-> (fr_exp_diff > EXP_W'(1)));

    // R7
    young_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s1_accept |-> s0_accept);

    // R6
    pair_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s1_accept |-> (cl_valid && fr_valid && cl_ready && fr_ready));

    // R8
    accept_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s0_accept |-> ((cl_valid && cl_ready) || (fr_valid && fr_ready)));

    // R9
    tag_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cl_valid && fr_valid) |-> (cl_tag != fr_tag));

endmodule

// File: tb/fpadd_dispatch_tb.sv
module fpadd_dispatch_tb;

    typedef struct {
        logic [31:0] a;
        logic [31:0] b;
        bit          sub;
    } req_t;

    typedef struct {
        bit          lane;   // 0 close, 1 far
        logic [31:0] a;
        logic [31:0] b;
        bit          tag;
        bit          esub;
        logic [7:0]  diff;
        bit          swap;
        logic [7:0]  ex;
        bit          sign;
    } item_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        s0_valid = 0, s1_valid = 0, s0_sub = 0, s1_sub = 0;
    logic [31:0] s0_a = 0, s0_b = 0, s1_a = 0, s1_b = 0;
    logic        s0_accept, s1_accept;
    logic        cl_valid, fr_valid;
    logic        cl_ready = 1, fr_ready = 1;
    logic [31:0] cl_a, cl_b, fr_a, fr_b;
    logic        cl_eff_sub, cl_tag, cl_swap, cl_sign;
    logic        fr_eff_sub, fr_tag, fr_swap, fr_sign;
    logic [7:0]  cl_exp_diff, cl_exp, fr_exp_diff, fr_exp;

    int n_tests = 0;
    int n_fail  = 0;

    req_t  pend[$];
    item_t exp_q[$];
    bit    exp_cv, exp_fv, exp_a0, exp_a1;
    bit    mon_en = 0;
    bit    tag_m  = 0;

    always #4 clk = ~clk;

    fpadd_dispatch u_dut (
        .clk(clk), .rst_n(rst_n),
        .s0_valid(s0_valid), .s0_a(s0_a), .s0_b(s0_b), .s0_sub(s0_sub), .s0_accept(s0_accept),
        .s1_valid(s1_valid), .s1_a(s1_a), .s1_b(s1_b), .s1_sub(s1_sub), .s1_accept(s1_accept),
        .cl_valid(cl_valid), .cl_ready(cl_ready), .cl_a(cl_a), .cl_b(cl_b),
        .cl_eff_sub(cl_eff_sub), .cl_tag(cl_tag), .cl_exp_diff(cl_exp_diff),
        .cl_swap(cl_swap), .cl_exp(cl_exp), .cl_sign(cl_sign),
        .fr_valid(fr_valid), .fr_ready(fr_ready), .fr_a(fr_a), .fr_b(fr_b),
        .fr_eff_sub(fr_eff_sub), .fr_tag(fr_tag), .fr_exp_diff(fr_exp_diff),
        .fr_swap(fr_swap), .fr_exp(fr_exp), .fr_sign(fr_sign)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
        end
    endtask

    function automatic logic [31:0] fp(input bit s, input int e, input int m);
        return {s, e[7:0], m[22:0]};
    endfunction

    // 0 close-only, 1 far-only, 2 either
    function automatic int need_of(input req_t r);
        bit esub;
        int ea, eb, g;
        esub = r.a[31] ^ r.b[31] ^ r.sub;
        ea = int'(r.a[30:23]);
        eb = int'(r.b[30:23]);
        g  = (ea > eb) ? ea - eb : eb - ea;
        if (g <= 1) return esub ? 0 : 2;
        return 1;
    endfunction

    function automatic item_t mk_item(input req_t r, input bit lane, input bit tag);
        item_t it;
        int ea, eb;
        bit sbe;
        it.lane = lane;
        it.a = r.a;
        it.b = r.b;
        it.tag = tag;
        sbe = r.b[31] ^ r.sub;
        it.esub = r.a[31] ^ sbe;
        ea = int'(r.a[30:23]);
        eb = int'(r.b[30:23]);
        it.swap = eb > ea;
        it.diff = 8'((ea > eb) ? ea - eb : eb - ea);
        it.ex   = 8'((ea > eb) ? ea : eb);
        if (!it.esub) it.sign = r.a[31];
        else if (r.a[30:0] == r.b[30:0]) it.sign = 1'b0;
        else if (r.b[30:0] > r.a[30:0]) it.sign = sbe;
        else it.sign = r.a[31];
        return it;
    endfunction

    // one cycle: drive head of pending list, build expectations, retire accepted
    task automatic step(input bit cr, input bit fr);
        bit v0, v1, oc, fits, ordy, yrdy, yg, a0, a1;
        int c0, c1;
        @(posedge clk);
        #1;
        cl_ready = cr;
        fr_ready = fr;
        v0 = pend.size() > 0;
        v1 = pend.size() > 1;
        s0_valid = v0;
        s1_valid = v1;
        c0 = 1;
        c1 = 1;
        if (v0) begin s0_a = pend[0].a; s0_b = pend[0].b; s0_sub = pend[0].sub; c0 = need_of(pend[0]); end
        if (v1) begin s1_a = pend[1].a; s1_b = pend[1].b; s1_sub = pend[1].sub; c1 = need_of(pend[1]); end
        oc   = (c0 == 0) || (c0 == 2 && v1 && c1 == 1);
        fits = v1 && (oc ? (c1 != 0) : (c1 != 1));
        ordy = oc ? cr : fr;
        yrdy = oc ? fr : cr;
        yg   = fits && ordy;
        a0   = v0 && ordy;
        a1   = yg && yrdy;
        exp_cv = (v0 && oc) || (yg && !oc);
        exp_fv = (v0 && !oc) || (yg && oc);
        exp_a0 = a0;
        exp_a1 = a1;
        if (a0) exp_q.push_back(mk_item(pend[0], !oc, tag_m));
        if (a1) exp_q.push_back(mk_item(pend[1], oc, !tag_m));
        @(negedge clk);
        #1;
        if (a0) void'(pend.pop_front());
        if (a1) void'(pend.pop_front());
        if (a0 ^ a1) tag_m = !tag_m;
    endtask

    task automatic drain(input int max_cyc);
        for (int i = 0; i < max_cyc && pend.size() > 0; i++) step(1, 1);
        chk(pend.size() == 0, "R5 R6 drain", 64'(pend.size()), 0);
    endtask

    task automatic push(input logic [31:0] a, input logic [31:0] b, input bit sub);
        req_t r;
        r.a = a; r.b = b; r.sub = sub;
        pend.push_back(r);
    endtask

    task automatic cmp_lane(input item_t it);
        bit          v, rd, t, es, sw, sg;
        logic [31:0] oa, ob;
        logic [7:0]  df, ex;
        if (it.lane == 0) begin
            v = cl_valid; rd = cl_ready; oa = cl_a; ob = cl_b; t = cl_tag; es = cl_eff_sub;
            df = cl_exp_diff; sw = cl_swap; ex = cl_exp; sg = cl_sign;
        end else begin
            v = fr_valid; rd = fr_ready; oa = fr_a; ob = fr_b; t = fr_tag; es = fr_eff_sub;
            df = fr_exp_diff; sw = fr_swap; ex = fr_exp; sg = fr_sign;
        end
        chk(v && rd, "R1 R2 R4 lane choice", {62'(0), v, rd}, 64'h3);
        chk(oa == it.a && ob == it.b, "R1 R2 R4 operands", {oa, ob}, {it.a, it.b});
        chk(t == it.tag, "R9 tag", 64'(t), 64'(it.tag));
        chk(es == it.esub, "R3 eff op", 64'(es), 64'(it.esub));
        chk(df == it.diff && sw == it.swap && ex == it.ex, "R10 exp precompute",
            {df, 7'd0, sw, ex}, {it.diff, 7'd0, it.swap, it.ex});
        chk(sg == it.sign, "R11 sign", 64'(sg), 64'(it.sign));
    endtask

    // monitor: compare outputs against the scoreboard at the falling edge
    always @(negedge clk) begin
        if (rst_n && mon_en) begin
            chk(cl_valid == exp_cv && fr_valid == exp_fv, "R5 R6 R8 valids",
                {cl_valid, fr_valid}, {exp_cv, exp_fv});
            chk(s0_accept == exp_a0 && s1_accept == exp_a1, "R6 R7 R8 accepts",
                {s0_accept, s1_accept}, {exp_a0, exp_a1});
            while (exp_q.size() > 0) cmp_lane(exp_q.pop_front());
        end
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // reset state, empty slots, and younger ignored without older (R7)
        s1_valid = 1; s1_a = fp(0, 100, 0); s1_b = fp(0, 100, 0);
        #1;
        chk(!cl_valid && !fr_valid, "R7 no issue without slot0", {cl_valid, fr_valid}, 0);
        chk(!s0_accept && !s1_accept, "R7 no accept without slot0", {s0_accept, s1_accept}, 0);
        @(posedge clk);
        #1 s1_valid = 0;
        mon_en = 1;

        // R1 R5: close-only older with far younger, paired; first tag 0 (R9)
        push(fp(0, 130, 1), fp(0, 130, 5), 1);
        push(fp(0, 140, 0), fp(0, 120, 0), 0);
        drain(4);
        // R2 R3: far-only sub older, younger with differing signs under add is a close sub
        push(fp(0, 150, 0), fp(0, 140, 3), 1);
        push(fp(1, 100, 7), fp(0, 101, 2), 0);
        drain(4);
        // R6 R11: two close-only, equal magnitudes give sign 0
        push(fp(0, 127, 10), fp(0, 127, 10), 1);
        push(fp(1, 127, 0), fp(0, 128, 0), 0);
        drain(4);
        // R4: both flexible, older FAR younger CLOSE
        push(fp(0, 127, 0), fp(0, 127, 1), 0);
        push(fp(1, 90, 0), fp(0, 91, 0), 1);
        drain(4);
        // R4: flexible older yields CLOSE to far-only younger
        push(fp(0, 60, 0), fp(0, 61, 0), 0);
        push(fp(0, 80, 0), fp(0, 70, 0), 1);
        drain(4);
        // R6: two far-only
        push(fp(0, 200, 0), fp(0, 10, 0), 0);
        push(fp(0, 50, 0), fp(1, 60, 0), 1);
        drain(4);
        // R4: lone flexible goes FAR; R11 larger b under sub
        push(fp(0, 10, 0), fp(0, 11, 0), 0);
        drain(3);
        push(fp(0, 100, 5), fp(0, 101, 5), 1);
        drain(3);
        // R8: older close stalls, younger far must wait
        push(fp(0, 70, 3), fp(0, 70, 1), 1);
        push(fp(0, 90, 0), fp(0, 20, 0), 0);
        step(0, 1);
        step(1, 0);
        step(1, 1);
        drain(3);
        // mixed traffic with varying readiness
        for (int i = 0; i < 60; i++) begin
            push(fp($urandom_range(1, 0), 100 + $urandom_range(3, 0), $urandom_range(4, 0)),
                 fp($urandom_range(1, 0), 100 + $urandom_range(3, 0), $urandom_range(4, 0)),
                 $urandom_range(1, 0));
        end
        for (int i = 0; i < 400 && pend.size() > 0; i++)
            step($urandom_range(3, 0) != 0, $urandom_range(3, 0) != 0);
        drain(200);

        mon_en = 0;
        @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule